// File: doc/BRIEF.md
# Single-Pin GPIO Output Controller

This block drives one general-purpose pad. Six 16-bit registers on a simple synchronous register bus choose where the pad's output level comes from. The level can be a static value written by software, that same value after a programmable on-delay, a free-running square wave for blinking an LED, an external function signal from elsewhere in the chip, or that external signal after the on-delay. The chosen level can be inverted before it reaches the pad. The driver enable comes either from a control bit or from the chosen level itself, which allows open-drain style driving. The pad input passes through a synchronizer and an optional inverter, and it can be read back.

All timing is in whole milliseconds, counted on a one-cycle-wide `ms_tick` strobe supplied from outside. The pad voltage select bit and the two pull-up bits are stored and read back but have no other effect. The output-routing register is also storage only.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: Registers sit at these bus offsets: 0 configuration, 1 routing, 2 drive, 3 input value (read-only), 4 toggle rate, 5 on-delay. The configuration bits are: source select [2:0], output invert [3], input invert [4], voltage select [5], enable override [6], output enable [7], pull A [8] and pull B [9]. Bits 15:10 read 0. The routing register keeps bits [7:0] and reads 0 above them. Rate and on-delay keep all 16 bits. A read returns data on `bus_rdata` in the cycle after the request, and offsets 6 and 7 read 0.
- R2: After reset every register reads 0, and `pad_oe` and `pad_out` are 0, so the pin is an undriven input.
- R3: The source select codes are 0 drive bit, 1 delayed drive bit, 2 toggle generator, 3 external function, 4 delayed external function, and 5 to 7 logic 0. With code 0, `pad_out` follows bit 0 of the drive register in the cycle after the write.
- R4: With code 2 and a rate N greater than 0, the output changes level every N ticks. Writing the rate restarts the generator from a low level. A rate of 0 holds the generator low whatever ticks arrive.
- R5: With a delayed source and an on-delay D greater than 0, the output goes high only after the source has been high for D ticks. With D = 0 the source passes through at once.
- R6: When a delayed source falls, the delayed output falls in the same cycle, and a new assertion waits the full D ticks again.
- R7: Code 3 passes `ext_func` straight through. Code 4 applies the on-delay of R5 and R6 to `ext_func`.
- R8: When the output-invert bit is 1, `pad_out` is the inverse of the selected level.
- R9: Bit 0 of the value register is `pad_in` after a two-stage synchronizer, XORed with the input-invert bit. Bits 15:1 read 0.
- R10: When the override bit is 0, `pad_oe` equals the output-enable bit. When the override bit is 1, `pad_oe` equals the selected level before output inversion.
- R11: Writes to offset 3 have no effect. The drive register keeps only bit 0, and the rest of its bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| ext_func | input | 1 | External function level, synchronous to clk |
| pad_in | input | 1 | Pad input level (asynchronous) |
| pad_out | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad driver enable |

## Verification
The assertions assume that `ms_tick` and `ext_func` are synchronous to `clk`. They also assume that a write lasts exactly one cycle, so `$past` of the bus fields identifies the write that was just accepted. The bench drives every input on the falling edge and pulses `ms_tick` high for one cycle with a low cycle after it, so each tick is counted once. Reads are sampled on the falling edge after the cycle that returns their data. `pad_in` is held for three cycles before a read, which covers the synchronizer.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    localparam int DW = 16;
    localparam int AW = 3;
    localparam int CFG_W = 10;
    localparam int ROUTE_W = 8;

    typedef enum logic [AW-1:0] {
        ADR_CFG   = 3'd0,
        ADR_ROUTE = 3'd1,
        ADR_DRIVE = 3'd2,
        ADR_VALUE = 3'd3,
        ADR_RATE  = 3'd4,
        ADR_DELAY = 3'd5
    } reg_addr_e;

    typedef enum logic [2:0] {
        SRC_DRIVE     = 3'd0,
        SRC_DRIVE_DLY = 3'd1,
        SRC_BLINK     = 3'd2,
        SRC_EXT       = 3'd3,
        SRC_EXT_DLY   = 3'd4
    } src_sel_e;

    typedef struct packed {
        logic       pull_b;
        logic       pull_a;
        logic       oe;
        logic       oe_ovr;
        logic       vsel;
        logic       in_inv;
        logic       out_inv;
        logic [2:0] src;
    } cfg_t;

    function automatic logic [DW-1:0] zext_cfg(input cfg_t c);
        return {{(DW-CFG_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          in_val,
    output logic [DW-1:0] bus_rdata,
    output logic [2:0]    src,
    output logic          out_inv,
    output logic          in_inv,
    output logic          oe,
    output logic          oe_ovr,
    output logic          drive,
    output logic [DW-1:0] rate,
    output logic          rate_wr,
    output logic [DW-1:0] delay
);

    cfg_t                cfg_q;
    logic [ROUTE_W-1:0]  route_q;
    logic                drive_q;
    logic [DW-1:0]       rate_q;
    logic [DW-1:0]       delay_q;
    logic                wr_en;
    logic                rd_en;
    logic [DW-1:0]       rd_mux;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            route_q <= '0;
            drive_q <= 1'b0;
            rate_q  <= '0;
            delay_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                ADR_CFG:   cfg_q   <= cfg_t'(bus_wdata[CFG_W-1:0]);
                ADR_ROUTE: route_q <= bus_wdata[ROUTE_W-1:0];
                ADR_DRIVE: drive_q <= bus_wdata[0];
                ADR_RATE:  rate_q  <= bus_wdata;
                ADR_DELAY: delay_q <= bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            ADR_CFG:   rd_mux = zext_cfg(cfg_q);
            ADR_ROUTE: rd_mux = {{(DW-ROUTE_W){1'b0}}, route_q};
            ADR_DRIVE: rd_mux = {{(DW-1){1'b0}}, drive_q};
            ADR_VALUE: rd_mux = {{(DW-1){1'b0}}, in_val};
            ADR_RATE:  rd_mux = rate_q;
            ADR_DELAY: rd_mux = delay_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
    end

    assign src     = cfg_q.src;
    assign out_inv = cfg_q.out_inv;
    assign in_inv  = cfg_q.in_inv;
    assign oe      = cfg_q.oe;
    assign oe_ovr  = cfg_q.oe_ovr;
    assign drive   = drive_q;
    assign rate    = rate_q;
    assign delay   = delay_q;
    assign rate_wr = wr_en && (bus_addr == ADR_RATE);

endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          restart,
    input  logic [CW-1:0] rate,
    output logic          lvl
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart || rate == '0) begin
            cnt_q <= '0;
            lvl   <= 1'b0;
        end else if (tick) begin
            if (cnt_q == rate - CW'(1)) begin
                cnt_q <= '0;
                lvl   <= ~lvl;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/gpio_on_delay.sv
module gpio_on_delay #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          src,
    input  logic [CW-1:0] limit,
    output logic          lvl,
    output logic [CW-1:0] cnt
);

    logic done_q;

    always_ff @(posedge clk) begin
        if (rst || !src) begin
            cnt    <= '0;
            done_q <= 1'b0;
        end else if (tick && !done_q && limit != '0) begin
            if (cnt == limit - CW'(1)) done_q <= 1'b1;
            else                       cnt    <= cnt + CW'(1);
        end
    end

    assign lvl = src && (limit == '0 || done_q);

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    input  logic          ms_tick,
    input  logic          ext_func,
    input  logic          pad_in,
    output logic          pad_out,
    output logic          pad_oe
);

    logic [2:0]    src;
    logic          out_inv, in_inv, oe, oe_ovr, drive, rate_wr;
    logic [DW-1:0] rate_val, delay_val;
    logic          blink_lvl, drv_dly_lvl, ext_dly_lvl;
    logic [DW-1:0] drv_dly_cnt, ext_dly_cnt;
    logic [SYNC_STAGES-1:0] sync_q;
    logic          in_val;
    logic          sel_lvl;

    // Input synchronizer chain
    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= pad_in;
    end

    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[i] <= 1'b0;
            else     sync_q[i] <= sync_q[i-1];
        end
    end

    assign in_val = sync_q[SYNC_STAGES-1] ^ in_inv;

    gpio_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .in_val    (in_val),
        .bus_rdata (bus_rdata),
        .src       (src),
        .out_inv   (out_inv),
        .in_inv    (in_inv),
        .oe        (oe),
        .oe_ovr    (oe_ovr),
        .drive     (drive),
        .rate      (rate_val),
        .rate_wr   (rate_wr),
        .delay     (delay_val)
    );

    gpio_blink #(.CW(DW)) u_blink (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .restart (rate_wr),
        .rate    (rate_val),
        .lvl     (blink_lvl)
    );

    gpio_on_delay #(.CW(DW)) u_drv_dly (
        .clk   (clk),
        .rst   (rst),
        .tick  (ms_tick),
        .src   (drive),
        .limit (delay_val),
        .lvl   (drv_dly_lvl),
        .cnt   (drv_dly_cnt)
    );

    gpio_on_delay #(.CW(DW)) u_ext_dly (
        .clk   (clk),
        .rst   (rst),
        .tick  (ms_tick),
        .src   (ext_func),
        .limit (delay_val),
        .lvl   (ext_dly_lvl),
        .cnt   (ext_dly_cnt)
    );

    always_comb begin
        case (src)
            SRC_DRIVE:     sel_lvl = drive;
            SRC_DRIVE_DLY: sel_lvl = drv_dly_lvl;
            SRC_BLINK:     sel_lvl = blink_lvl;
            SRC_EXT:       sel_lvl = ext_func;
            SRC_EXT_DLY:   sel_lvl = ext_dly_lvl;
            default:       sel_lvl = 1'b0;
        endcase
    end

    assign pad_out = sel_lvl ^ out_inv;
    assign pad_oe  = oe_ovr ? sel_lvl : oe;

endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        ms_tick,
    input logic        pad_oe,
    input logic        blink_lvl,
    input logic        rate_wr,
    input logic [15:0] rate_val,
    input logic        drive,
    input logic [15:0] drv_dly_cnt
);

    AST_RESET_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pad_oe); // R2

    AST_OE_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 3'd0 && !bus_wdata[6]) |=> (pad_oe == $past(bus_wdata[7]))); // R10

    AST_BLINK_ZERO_RATE: assert property (@(posedge clk) disable iff (rst)
        (rate_val == 16'd0 && $past(rate_val) == 16'd0 && !$past(rst)) |-> !blink_lvl); // R4

    AST_BLINK_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(blink_lvl) |-> ($past(ms_tick) || $past(rate_wr) || $past(rst))); // R4

    AST_DELAY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !drive |=> (drv_dly_cnt == 16'd0 || drive)); // R6

    AST_VALUE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 3'd3) |=> (bus_rdata[15:1] == 15'd0)); // R9

endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ms_tick     (ms_tick),
    .pad_oe      (pad_oe),
    .blink_lvl   (blink_lvl),
    .rate_wr     (rate_wr),
    .rate_val    (rate_val),
    .drive       (drive),
    .drv_dly_cnt (drv_dly_cnt)
);

// File: tb/tb_gpio_pin_ctrl.sv
module tb_gpio_pin_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ms_tick = 1'b0;
    logic        ext_func = 1'b0;
    logic        pad_in = 1'b0;
    logic        pad_out;
    logic        pad_oe;

    int checks = 0;
    int errors = 0;
    logic rd_pend = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    gpio_pin_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ms_tick   (ms_tick),
        .ext_func  (ext_func),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // Monitor: compares each returned read against the queued expectation
    always @(posedge clk) rd_pend <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic pin(input logic eo, input logic ee, input string t);
        checks++;
        if (pad_out !== eo || pad_oe !== ee) begin
            errors++;
            $display("FAIL %s: out/oe actual %b%b expected %b%b", t, pad_out, pad_oe, eo, ee);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        pin(1'b0, 1'b0, "R2 reset pins");
        rd(3'd0, 16'h0000, "R2 cfg reset");
        rd(3'd4, 16'h0000, "R2 rate reset");

        // R1 register map and reserved bits
        wr(3'd1, 16'hABCD);
        rd(3'd1, 16'h00CD, "R1 routing");
        wr(3'd5, 16'hBEEF);
        rd(3'd5, 16'hBEEF, "R1 delay");
        rd(3'd6, 16'h0000, "R1 unused offset");
        wr(3'd0, 16'hFC20);
        rd(3'd0, 16'h0020, "R1 cfg mask");
        // R11 drive keeps bit 0 only
        wr(3'd2, 16'hFFFE);
        rd(3'd2, 16'h0000, "R11 drive mask");

        // R3 static drive, oe=1
        wr(3'd0, 16'h0080);
        pin(1'b0, 1'b1, "R3 drive low");
        wr(3'd2, 16'h0001);
        pin(1'b1, 1'b1, "R3 drive high");
        wr(3'd0, 16'h0085);
        pin(1'b0, 1'b1, "R3 code 5 gives 0");
        // R8 output invert
        wr(3'd0, 16'h0088);
        pin(1'b0, 1'b1, "R8 inverted high");
        wr(3'd2, 16'h0000);
        pin(1'b1, 1'b1, "R8 inverted low");

        // R10 enable sources
        wr(3'd0, 16'h0000);
        pin(1'b0, 1'b0, "R10 oe bit 0");
        wr(3'd0, 16'h0040);
        pin(1'b0, 1'b0, "R10 override low");
        wr(3'd2, 16'h0001);
        pin(1'b1, 1'b1, "R10 override high");

        // R4 toggle generator
        wr(3'd0, 16'h0082);
        wr(3'd4, 16'd3);
        tick(2);
        pin(1'b0, 1'b1, "R4 before first step");
        tick(1);
        pin(1'b1, 1'b1, "R4 first step");
        tick(3);
        pin(1'b0, 1'b1, "R4 second step");
        tick(3);
        pin(1'b1, 1'b1, "R4 third step");
        wr(3'd4, 16'd3);
        pin(1'b0, 1'b1, "R4 restart low");
        wr(3'd4, 16'd0);
        tick(5);
        pin(1'b0, 1'b1, "R4 zero rate holds");

        // R5 / R6 delayed drive
        wr(3'd2, 16'h0000);
        wr(3'd5, 16'd3);
        wr(3'd0, 16'h0081);
        wr(3'd2, 16'h0001);
        tick(2);
        pin(1'b0, 1'b1, "R5 still waiting");
        tick(1);
        pin(1'b1, 1'b1, "R5 delay elapsed");
        wr(3'd2, 16'h0000);
        pin(1'b0, 1'b1, "R6 immediate drop");
        wr(3'd2, 16'h0001);
        tick(2);
        pin(1'b0, 1'b1, "R6 full wait again");
        tick(1);
        pin(1'b1, 1'b1, "R6 second elapse");
        wr(3'd5, 16'd0);
        wr(3'd2, 16'h0000);
        wr(3'd2, 16'h0001);
        pin(1'b1, 1'b1, "R5 zero delay passes");

        // R7 external function
        wr(3'd0, 16'h0083);
        @(negedge clk); ext_func = 1'b1;
        @(negedge clk);
        pin(1'b1, 1'b1, "R7 ext direct high");
        ext_func = 1'b0;
        @(negedge clk);
        pin(1'b0, 1'b1, "R7 ext direct low");
        wr(3'd5, 16'd2);
        wr(3'd0, 16'h0084);
        @(negedge clk); ext_func = 1'b1;
        tick(1);
        pin(1'b0, 1'b1, "R7 ext delayed waiting");
        tick(1);
        pin(1'b1, 1'b1, "R7 ext delayed high");

        // R9 input path, R11 value reg read-only
        pad_in = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd3, 16'h0001, "R9 input high");
        wr(3'd0, 16'h0010);
        rd(3'd3, 16'h0000, "R9 input inverted");
        pad_in = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd3, 16'h0001, "R9 low inverted");
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'hFFFF);
        rd(3'd3, 16'h0000, "R11 value write ignored");
        rd(3'd0, 16'h0000, "R11 cfg untouched");

        repeat (4) @(negedge clk);
        summary();
    end

endmodule